// File: doc/BRIEF.md
# Per-Channel DAC Calibration Scaler

This block turns a normalized output request into a calibrated 14-bit converter code for one of up to sixteen analog channels. Every channel keeps two independent endpoint pairs, one for voltage operation and one for current-loop operation. Each pair holds a low code and a high code. In voltage mode they are the codes that land exactly on -10 V and +10 V. In current mode they land on 0 mA and 20 mA. A request names a channel, a mode and an unsigned 16-bit fraction. The block interpolates linearly between the selected endpoints, rounds, and limits the answer to the legal code range. It flags any result that had to be limited.

Every result goes back over a valid/ready interface. In the same clock edge it is parked in that channel's holding latch. The converter-facing outputs only move when a global update strobe copies all holding latches at once, so several channels can be set up and then changed together. Endpoints are loaded through a simple write port. Endpoints are stored as signed 16-bit values, so a calibration that falls outside the code range can still be held.

Top module: `calib_scaler`

## Requirements
- R1: After reset, reqReady is 1, resValid is 0, every dacOut slice is 0, and every endpoint pair in both modes holds low = 0 and high = 0x3FFF.
- R2: When calWrEn is 1 at a rising edge, calData (16-bit two's complement) is stored as the endpoint chosen by calCh, calMode (0 = voltage, 1 = current) and calSel (0 = low endpoint, 1 = high endpoint). No other endpoint changes.
- R3: The result is lo + floor(((hi - lo) * t + 32768) / 65536). Here t is reqTarget taken as an unsigned fraction of 65536. lo and hi are the signed endpoints for reqCh in the pair chosen by reqMode. The voltage pair and the current pair of a channel never affect each other.
- R4: A computed value below 0 gives resCode 0, and one above 16383 gives 16383. resClamp is 1 exactly when this limiting happened.
- R5: A request accepted at rising edge k shows resValid = 1 after edge k+1 and resValid = 0 between edges k and k+1, when the result side was empty and ready.
- R6: While resValid is 1 and resReady is 0, resValid, resCode and resClamp hold. Results leave in request order. reqReady is 0 only while both the computing stage and the result stage are full and the result is not being taken. reqReady is 1 whenever resValid is 0.
- R7: At the edge where a result is produced, its code is written into the holding latch of its channel. dacOut does not change at that edge.
- R8: A rising edge with updStrobe = 1 copies all holding latches to their dacOut slices at once. dacOut changes at no other edge.
- R9: When a result is produced in the same edge as an update strobe, dacOut takes the holding value from before that edge. The new code reaches dacOut at the next strobe.
- R10: The endpoints used for a request are taken at the edge it is accepted. An endpoint write after that edge affects only later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| calWrEn | input | 1 | Endpoint write enable |
| calCh | input | 4 | Endpoint write channel |
| calMode | input | 1 | Endpoint write mode, 0 voltage, 1 current |
| calSel | input | 1 | Endpoint select, 0 low, 1 high |
| calData | input | 16 | Endpoint value, two's complement |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Request ready |
| reqCh | input | 4 | Request channel |
| reqMode | input | 1 | Request mode, 0 voltage, 1 current |
| reqTarget | input | 16 | Unsigned target fraction |
| resValid | output | 1 | Result valid |
| resReady | input | 1 | Result ready |
| resCode | output | 14 | Calibrated, limited code |
| resClamp | output | 1 | Result was limited |
| updStrobe | input | 1 | Copy all holding latches to outputs |
| dacOut | output | 224 | Output codes, channel c at bits [14c+13:14c] |

## Verification
Two events can land on the same clock edge. A computed result can be written into a channel's holding latch in the edge where the update strobe copies all holding latches. A calibration write can also land in the edge while a request for that channel is still in flight. The first case is provoked by first leaving a fresh, uncopied code in the holding latch. The strobe is then raised in exactly the cycle the next result for that channel is produced. dacOut must show the older holding value, and the newer code must appear only after one more strobe. The second case writes a new high endpoint in the cycle after a request is accepted. The bench expects the result built from the old endpoints, and the new endpoints on the following request.

// File: rtl/calsc_pkg.sv
package calsc_pkg;

  typedef struct packed {
    logic capture;   // request accepted into computing stage
    logic produce;   // computing stage moves into result stage
  } ctlStrobe_t;

  typedef enum logic {
    MODE_VOLT = 1'b0,
    MODE_CURR = 1'b1
  } calMode_e;

endpackage

// File: rtl/calsc_ctrl.sv
module calsc_ctrl
  import calsc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       resReady,
  output logic       reqReady,
  output logic       resValid,
  output ctlStrobe_t stb
);

  logic s1Valid;
  logic resValidQ;
  logic advance;

  always_comb begin
    advance     = !resValidQ || resReady;
    reqReady    = !s1Valid || advance;
    stb.capture = reqValid && reqReady;
    stb.produce = s1Valid && advance;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid   <= 1'b0;
      resValidQ <= 1'b0;
    end else begin
      if (stb.capture)      s1Valid <= 1'b1;
      else if (stb.produce) s1Valid <= 1'b0;

      if (stb.produce)      resValidQ <= 1'b1;
      else if (resReady)    resValidQ <= 1'b0;
    end
  end

  assign resValid = resValidQ;

endmodule

// File: rtl/calsc_dp.sv
module calsc_dp
  import calsc_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int CODE_W = 14,
  parameter int FRAC_W = 16,
  parameter int CAL_W  = 16,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
)(
  input  logic                     clk,
  input  logic                     rstN,
  input  ctlStrobe_t               stb,
  input  logic                     calWrEn,
  input  logic [CH_W-1:0]          calCh,
  input  logic                     calMode,
  input  logic                     calSel,
  input  logic [CAL_W-1:0]         calData,
  input  logic [CH_W-1:0]          reqCh,
  input  logic                     reqMode,
  input  logic [FRAC_W-1:0]        reqTarget,
  input  logic                     updStrobe,
  output logic [CODE_W-1:0]        resCode,
  output logic                     resClamp,
  output logic [NUM_CH*CODE_W-1:0] dacOut
);

  localparam int NUM_PAIR = 2 * NUM_CH;
  localparam int PROD_W   = CAL_W + FRAC_W + 2;
  localparam logic signed [PROD_W-1:0] HALF     = PROD_W'(1) <<< (FRAC_W - 1);
  localparam logic signed [PROD_W-1:0] CODE_TOP = (PROD_W'(1) <<< CODE_W) - PROD_W'(1);
  localparam logic signed [CAL_W-1:0]  CAL_TOP  = CAL_W'((1 << CODE_W) - 1);

  logic signed [CAL_W-1:0]  calLo [NUM_PAIR];
  logic signed [CAL_W-1:0]  calHi [NUM_PAIR];
  logic signed [CAL_W-1:0]  s1Lo, s1Hi;
  logic [FRAC_W-1:0]        s1Target;
  logic [CH_W-1:0]          s1Ch;
  logic [CODE_W-1:0]        holdReg [NUM_CH];
  logic [CODE_W-1:0]        outReg  [NUM_CH];

  logic signed [CAL_W:0]    span;
  logic signed [PROD_W-1:0] prod, scaled, total;
  logic [CODE_W-1:0]        limCode;
  logic                     limFlag;

  function automatic int pairIdx(input logic m, input logic [CH_W-1:0] c);
    return int'(m) * NUM_CH + int'(c);
  endfunction

  // endpoint storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_PAIR; i++) begin
        calLo[i] <= '0;
        calHi[i] <= CAL_TOP;
      end
    end else if (calWrEn) begin
      if (calSel) calHi[pairIdx(calMode, calCh)] <= calData;
      else        calLo[pairIdx(calMode, calCh)] <= calData;
    end
  end

  // snapshot at acceptance
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Lo     <= '0;
      s1Hi     <= '0;
      s1Target <= '0;
      s1Ch     <= '0;
    end else if (stb.capture) begin
      s1Lo     <= calLo[pairIdx(reqMode, reqCh)];
      s1Hi     <= calHi[pairIdx(reqMode, reqCh)];
      s1Target <= reqTarget;
      s1Ch     <= reqCh;
    end
  end

  // interpolation, rounding, limiting
  always_comb begin
    span   = (CAL_W+1)'(s1Hi) - (CAL_W+1)'(s1Lo);
    prod   = PROD_W'(span) * $signed(PROD_W'({1'b0, s1Target}));
    scaled = (prod + HALF) >>> FRAC_W;
    total  = scaled + PROD_W'(s1Lo);
    if (total < 0) begin
      limCode = '0;
      limFlag = 1'b1;
    end else if (total > CODE_TOP) begin
      limCode = '1;
      limFlag = 1'b1;
    end else begin
      limCode = total[CODE_W-1:0];
      limFlag = 1'b0;
    end
  end

  // result register and holding latches
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resCode  <= '0;
      resClamp <= 1'b0;
      for (int i = 0; i < NUM_CH; i++) holdReg[i] <= '0;
    end else if (stb.produce) begin
      resCode       <= limCode;
      resClamp      <= limFlag;
      holdReg[s1Ch] <= limCode;
    end
  end

  // output latches
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CH; i++) outReg[i] <= '0;
    end else if (updStrobe) begin
      for (int i = 0; i < NUM_CH; i++) outReg[i] <= holdReg[i];
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gOut
    assign dacOut[g*CODE_W +: CODE_W] = outReg[g];
  end

endmodule

// File: rtl/calib_scaler.sv
module calib_scaler
  import calsc_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int CODE_W = 14,
  parameter int FRAC_W = 16,
  parameter int CAL_W  = 16,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
)(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     calWrEn,
  input  logic [CH_W-1:0]          calCh,
  input  logic                     calMode,
  input  logic                     calSel,
  input  logic [CAL_W-1:0]         calData,
  input  logic                     reqValid,
  output logic                     reqReady,
  input  logic [CH_W-1:0]          reqCh,
  input  logic                     reqMode,
  input  logic [FRAC_W-1:0]        reqTarget,
  output logic                     resValid,
  input  logic                     resReady,
  output logic [CODE_W-1:0]        resCode,
  output logic                     resClamp,
  input  logic                     updStrobe,
  output logic [NUM_CH*CODE_W-1:0] dacOut
);

  ctlStrobe_t stb;

  calsc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .resReady (resReady),
    .reqReady (reqReady),
    .resValid (resValid),
    .stb      (stb)
  );

  calsc_dp #(
    .NUM_CH (NUM_CH),
    .CODE_W (CODE_W),
    .FRAC_W (FRAC_W),
    .CAL_W  (CAL_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .calWrEn   (calWrEn),
    .calCh     (calCh),
    .calMode   (calMode),
    .calSel    (calSel),
    .calData   (calData),
    .reqCh     (reqCh),
    .reqMode   (reqMode),
    .reqTarget (reqTarget),
    .updStrobe (updStrobe),
    .resCode   (resCode),
    .resClamp  (resClamp),
    .dacOut    (dacOut)
  );

endmodule

// File: rtl/calsc_checker.sv
module calsc_checker #(
  parameter int NUM_CH = 16,
  parameter int CODE_W = 14
)(
  input logic                     clk,
  input logic                     rstN,
  input logic                     reqValid,
  input logic                     reqReady,
  input logic                     resValid,
  input logic                     resReady,
  input logic [CODE_W-1:0]        resCode,
  input logic                     resClamp,
  input logic                     updStrobe,
  input logic [NUM_CH*CODE_W-1:0] dacOut
);

  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    resValid && !resReady |=> resValid && $stable(resCode) && $stable(resClamp)); // R6

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> reqReady); // R6

  AST_CLAMP_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    resValid && resClamp |-> (resCode == '0 || resCode == '1)); // R4

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> ##1 resValid); // R5

  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !updStrobe |=> $stable(dacOut)); // R8

endmodule

bind calib_scaler calsc_checker #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .resValid  (resValid),
  .resReady  (resReady),
  .resCode   (resCode),
  .resClamp  (resClamp),
  .updStrobe (updStrobe),
  .dacOut    (dacOut)
);

// File: tb/calib_scaler_bench.sv
module calib_scaler_bench;

  localparam int NCH = 16;
  localparam int CW  = 14;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            calWrEn = 1'b0;
  logic [3:0]      calCh = '0;
  logic            calMode = 1'b0;
  logic            calSel = 1'b0;
  logic [15:0]     calData = '0;
  logic            reqValid = 1'b0;
  logic            reqReady;
  logic [3:0]      reqCh = '0;
  logic            reqMode = 1'b0;
  logic [15:0]     reqTarget = '0;
  logic            resValid;
  logic            resReady = 1'b1;
  logic [CW-1:0]   resCode;
  logic            resClamp;
  logic            updStrobe = 1'b0;
  logic [NCH*CW-1:0] dacOut;

  int total = 0;
  int bad   = 0;
  int gotCode, gotClamp;

  always #2 clk = ~clk;

  calib_scaler u_calib_scaler (
    .clk(clk), .rstN(rstN),
    .calWrEn(calWrEn), .calCh(calCh), .calMode(calMode), .calSel(calSel), .calData(calData),
    .reqValid(reqValid), .reqReady(reqReady), .reqCh(reqCh), .reqMode(reqMode), .reqTarget(reqTarget),
    .resValid(resValid), .resReady(resReady), .resCode(resCode), .resClamp(resClamp),
    .updStrobe(updStrobe), .dacOut(dacOut)
  );

  typedef struct packed {
    logic [3:0]  ch;
    logic        mode;
    logic [15:0] lo;
    logic [15:0] hi;
    logic [15:0] tgt;
    logic [13:0] code;
    logic        clamp;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{4'd0,  1'b0, 16'd100,  16'd16200, 16'h0000, 14'd100,   1'b0},
    '{4'd1,  1'b0, 16'd100,  16'd16200, 16'hFFFF, 14'd16200, 1'b0},
    '{4'd2,  1'b0, 16'd0,    16'd16383, 16'h8000, 14'd8192,  1'b0},
    '{4'd3,  1'b1, 16'd8191, 16'd16383, 16'h4000, 14'd10239, 1'b0},
    '{4'd4,  1'b0, 16'd0,    16'd3,     16'h8000, 14'd2,     1'b0},
    '{4'd5,  1'b0, 16'd0,    16'd20000, 16'hFFFF, 14'd16383, 1'b1},
    '{4'd6,  1'b1, 16'hFE0C, 16'd15000, 16'h0000, 14'd0,     1'b1},
    '{4'd7,  1'b0, 16'd16000,16'd0,     16'h4000, 14'd12000, 1'b0},
    '{4'd15, 1'b1, 16'd1000, 16'd9000,  16'h2000, 14'd2000,  1'b0}
  };

  function automatic int slice(input int c);
    return int'(dacOut[c*CW +: CW]);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic calWrite(input int ch, input logic mode, input logic sel, input logic [15:0] val);
    @(negedge clk);
    calWrEn = 1'b1; calCh = 4'(ch); calMode = mode; calSel = sel; calData = val;
    @(negedge clk);
    calWrEn = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk);
    updStrobe = 1'b1;
    @(negedge clk);
    updStrobe = 1'b0;
  endtask

  // request, with optional update strobe in the cycle the result is produced
  task automatic sendReq(input int ch, input logic mode, input logic [15:0] tgt, input bit withStrobe);
    @(negedge clk);
    reqCh = 4'(ch); reqMode = mode; reqTarget = tgt; reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid  = 1'b0;
    updStrobe = withStrobe;
    chk("R5 resValid one cycle after accept", int'(resValid), 0);
    @(negedge clk);
    updStrobe = 1'b0;
    chk("R5 resValid two edges after accept", int'(resValid), 1);
    gotCode  = int'(resCode);
    gotClamp = int'(resClamp);
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL R5 watchdog expired actual=hang expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reqReady", int'(reqReady), 1);
    chk("R1 resValid", int'(resValid), 0);
    chk("R1 dacOut zero", int'(dacOut == '0), 1);
    rstN = 1'b1;

    // R1 default endpoints: low 0, high 0x3FFF gives mid code
    sendReq(9, 1'b1, 16'h8000, 1'b0);
    chk("R1 default current pair", gotCode, 8192);

    // R2 R3 R4 R7 R8 vector table
    for (int i = 0; i < NV; i++) begin
      calWrite(int'(VECS[i].ch), VECS[i].mode, 1'b0, VECS[i].lo);
      calWrite(int'(VECS[i].ch), VECS[i].mode, 1'b1, VECS[i].hi);
      sendReq(int'(VECS[i].ch), VECS[i].mode, VECS[i].tgt, 1'b0);
      chk($sformatf("R3 code vec%0d", i), gotCode, int'(VECS[i].code));
      chk($sformatf("R4 clamp vec%0d", i), gotClamp, int'(VECS[i].clamp));
      chk($sformatf("R7 output unchanged before strobe vec%0d", i), slice(int'(VECS[i].ch)), 0);
      strobe();
      chk($sformatf("R8 output after strobe vec%0d", i), slice(int'(VECS[i].ch)), int'(VECS[i].code));
    end
    chk("R8 untouched channel", slice(9), 8192);

    // R3 voltage pair of ch3 untouched by its current-pair writes
    sendReq(3, 1'b0, 16'h8000, 1'b0);
    chk("R3 mode pairs independent", gotCode, 8192);

    // R10 endpoint write while request in flight
    @(negedge clk);
    reqCh = 4'd4; reqMode = 1'b0; reqTarget = 16'h8000; reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    calWrEn = 1'b1; calCh = 4'd4; calMode = 1'b0; calSel = 1'b1; calData = 16'd16383;
    @(negedge clk);
    calWrEn = 1'b0;
    chk("R10 in-flight uses snapshot", int'(resCode), 2);
    sendReq(4, 1'b0, 16'h8000, 1'b0);
    chk("R10 next request uses new endpoint", gotCode, 8192);

    // R7 R9 holding write colliding with update strobe on ch0
    sendReq(0, 1'b0, 16'h8000, 1'b0);
    chk("R7 new code", gotCode, 8150);
    chk("R7 output still old", slice(0), 100);
    sendReq(0, 1'b0, 16'hFFFF, 1'b1);
    chk("R9 collision code", gotCode, 16200);
    chk("R9 output takes previous holding value", slice(0), 8150);
    strobe();
    chk("R9 new code after next strobe", slice(0), 16200);

    // R6 backpressure and ordering
    @(negedge clk);
    resReady = 1'b0;
    reqCh = 4'd2; reqMode = 1'b0; reqTarget = 16'h8000; reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqCh = 4'd15; reqMode = 1'b1; reqTarget = 16'h2000;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    chk("R6 first result valid", int'(resValid), 1);
    chk("R6 first result code", int'(resCode), 8192);
    chk("R6 reqReady low when full", int'(reqReady), 0);
    repeat (2) @(negedge clk);
    chk("R6 result held", int'(resCode), 8192);
    chk("R6 reqReady still low", int'(reqReady), 0);
    resReady = 1'b1;
    @(negedge clk);
    chk("R6 second result in order", int'(resCode), 2000);
    chk("R6 second result valid", int'(resValid), 1);
    @(negedge clk);
    chk("R6 drained", int'(resValid), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule